// File: doc/BRIEF.md
# Front-End Branch Redirect Controller

This block picks the next fetch address for a five-stage in-order pipeline and decides which younger instructions to squash. Three mechanisms can steer fetch. A small direct-mapped target buffer is looked up with the fetch address. A table of 2-bit counters is read for the branch sitting in decode. The resolved outcome of the branch in execute can overrule both. When nothing intervenes, fetch advances by one 4-byte word.

Each steering point has its own cost. A correction from execute discards both fetch and decode, so it costs two bubbles. A decode-time redirect discards only the fetch slot, so it costs one bubble. A target-buffer hit steers fetch with no bubble. The redirect outputs and the two kill strobes are combinational and are consumed by the surrounding pipeline registers at the next clock edge. Both predictor tables are trained at that edge from the branch resolved in execute.

Top module: `fe_redirect_ctrl`

## Requirements
- R1: When there is no correction from execute, no redirect from decode and no target-buffer hit, `next_pc` = `if_pc` + 4, and `if_kill` and `dec_kill` are both 0.
- R2: A valid branch in execute whose `ex_taken` differs from `ex_pred_taken` asserts `if_kill` and `dec_kill` in the same cycle. `next_pc` is then `ex_target` when the branch is taken and `ex_pc` + 4 when it is not.
- R3: A decode redirect happens when `id_valid` and `id_is_branch` are 1, the counter predicts taken and `id_fetch_taken` is 0. It sets `next_pc` = `id_target`, `if_kill` = 1 and `dec_kill` = 0. `id_bht_taken` always shows the counter's prediction for `id_bht_idx`.
- R4: Each counter has 2 bits: 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. It predicts taken when its value is 2 or 3. It counts up on taken and down on not-taken, and stops at 0 and 3. The counter is selected by PC bits [2 +: BHT_IDX_W].
- R5: A valid branch in execute updates its counter at the clock edge. The new prediction is visible from the next cycle.
- R6: A taken branch resolved in execute writes the target-buffer entry at index PC[2 +: BTB_IDX_W], with tag PC[PC_W-1 : 2+BTB_IDX_W] and target `ex_target`. From the next cycle, a fetch of that PC sees `if_btb_hit` = 1 and `next_pc` = the stored target. A fetch address with the same index but a different tag misses.
- R7: A branch resolved not-taken while `ex_pred_taken` = 1 invalidates its target-buffer entry if the tag matches. A later fetch of that PC misses.
- R8: Sources of `next_pc` in priority order: correction from execute, then decode redirect, then target-buffer hit, then `if_pc` + 4.
- R9: In a cycle with a correction from execute, no decode redirect happens.
- R10: When `id_fetch_taken` = 1, no decode redirect happens.
- R11: In the cycle of a valid resolved branch, `bht_upd` = 1. `btb_alloc` = 1 when that branch is taken. `btb_inval` = 1 when it is not taken while predicted taken. All three are 0 otherwise.
- R12: After reset, every counter holds 1 (weak not-taken) and every target-buffer entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_pc | input | PC_W | Address being fetched |
| if_btb_hit | output | 1 | Target buffer hits for `if_pc` |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_bht_idx | input | BHT_IDX_W | PC bits [2 +: BHT_IDX_W] of the decode instruction |
| id_target | input | PC_W | Branch target computed in decode |
| id_fetch_taken | input | 1 | Fetch already steered this instruction's successor to the target |
| id_bht_taken | output | 1 | Counter prediction for `id_bht_idx` |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_is_branch | input | 1 | Execute instruction is a conditional branch |
| ex_pc | input | PC_W | Address of the execute instruction |
| ex_target | input | PC_W | Resolved branch target |
| ex_taken | input | 1 | Resolved branch outcome |
| ex_pred_taken | input | 1 | Outcome the front end assumed for this branch |
| next_pc | output | PC_W | Address to fetch next |
| if_kill | output | 1 | Squash the instruction in fetch |
| dec_kill | output | 1 | Squash the instruction in decode |
| bht_upd | output | 1 | Counter table is trained at this edge |
| btb_alloc | output | 1 | Target-buffer entry is written at this edge |
| btb_inval | output | 1 | Target-buffer invalidate is requested at this edge |

## Verification
`next_pc`, both kills, `if_btb_hit`, `id_bht_taken` and the three update strobes depend combinationally on the current inputs and the table state. The bench therefore drives each stimulus half a nanosecond after a rising edge and samples one nanosecond later, inside the same cycle. Table writes take effect at the following rising edge. The bench's own counter and target-buffer model advances at that same edge, so a prediction trained in cycle N is first compared in cycle N+1. The counter sweep reads each counter in every cycle before its update lands, which covers both saturation ends one cycle at a time.

// File: rtl/fe_redirect_pkg.sv
package fe_redirect_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_t;

  // Saturating step of a 2-bit direction counter.
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      case (cur)
        CTR_SNT: nxt = CTR_WNT;
        CTR_WNT: nxt = CTR_WT;
        default: nxt = CTR_ST;
      endcase
    end else begin
      case (cur)
        CTR_ST:  nxt = CTR_WT;
        CTR_WT:  nxt = CTR_WNT;
        default: nxt = CTR_SNT;
      endcase
    end
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return (cur == CTR_WT) || (cur == CTR_ST);
  endfunction

endpackage

// File: rtl/fe_bht.sv
module fe_bht
  import fe_redirect_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t ctr_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WNT;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= ctr_next(ctr_q[upd_idx], upd_taken);
    end
  end

  assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);
endmodule

// File: rtl/fe_btb.sv
module fe_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  input  logic            alloc_en,
  input  logic            inval_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - 2 - IDX_W;

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  logic [PC_W-1:0]  tgt_q   [ENTRIES];

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[2 +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  logic [IDX_W-1:0] rd_idx, upd_idx;
  logic             upd_match;

  assign rd_idx    = idx_of(rd_pc);
  assign upd_idx   = idx_of(upd_pc);
  assign upd_match = valid_q[upd_idx] && (tag_q[upd_idx] == tag_of(upd_pc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (alloc_en) begin
      valid_q[upd_idx] <= 1'b1;
    end else if (inval_en && upd_match) begin
      valid_q[upd_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[upd_idx] <= tag_of(upd_pc);
      tgt_q[upd_idx] <= upd_target;
    end
  end

  assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc));
  assign rd_target = tgt_q[rd_idx];
endmodule

// File: rtl/fe_pc_select.sv
module fe_pc_select #(
  parameter int PC_W = 32
) (
  input  logic            ex_fix,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_pc,
  input  logic [PC_W-1:0] ex_target,
  input  logic            id_redir,
  input  logic [PC_W-1:0] id_target,
  input  logic            btb_hit,
  input  logic [PC_W-1:0] btb_target,
  input  logic [PC_W-1:0] if_pc,
  output logic [PC_W-1:0] next_pc
);
  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  always_comb begin
    if (ex_fix)        next_pc = ex_taken ? ex_target : seq_pc(ex_pc);
    else if (id_redir) next_pc = id_target;
    else if (btb_hit)  next_pc = btb_target;
    else               next_pc = seq_pc(if_pc);
  end
endmodule

// File: rtl/fe_redirect_ctrl.sv
module fe_redirect_ctrl #(
  parameter int PC_W      = 32,
  parameter int BHT_IDX_W = 4,
  parameter int BTB_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      if_pc,
  output logic                 if_btb_hit,
  input  logic                 id_valid,
  input  logic                 id_is_branch,
  input  logic [BHT_IDX_W-1:0] id_bht_idx,
  input  logic [PC_W-1:0]      id_target,
  input  logic                 id_fetch_taken,
  output logic                 id_bht_taken,
  input  logic                 ex_valid,
  input  logic                 ex_is_branch,
  input  logic [PC_W-1:0]      ex_pc,
  input  logic [PC_W-1:0]      ex_target,
  input  logic                 ex_taken,
  input  logic                 ex_pred_taken,
  output logic [PC_W-1:0]      next_pc,
  output logic                 if_kill,
  output logic                 dec_kill,
  output logic                 bht_upd,
  output logic                 btb_alloc,
  output logic                 btb_inval
);
  // Named internal events, observed by the bound checker.
  logic            ex_resolve;
  logic            ex_fix;
  logic            id_redir;
  logic [PC_W-1:0] btb_target;

  assign ex_resolve = ex_valid && ex_is_branch;
  assign ex_fix     = ex_resolve && (ex_taken != ex_pred_taken);
  assign id_redir   = id_valid && id_is_branch && id_bht_taken
                      && !id_fetch_taken && !ex_fix;

  assign bht_upd   = ex_resolve;
  assign btb_alloc = ex_resolve && ex_taken;
  assign btb_inval = ex_resolve && !ex_taken && ex_pred_taken;

  assign if_kill  = ex_fix || id_redir;
  assign dec_kill = ex_fix;

  fe_bht #(.IDX_W(BHT_IDX_W)) bht_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (id_bht_idx),
    .rd_taken  (id_bht_taken),
    .upd_en    (bht_upd),
    .upd_idx   (ex_pc[2 +: BHT_IDX_W]),
    .upd_taken (ex_taken)
  );

  fe_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) btb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_pc      (if_pc),
    .rd_hit     (if_btb_hit),
    .rd_target  (btb_target),
    .alloc_en   (btb_alloc),
    .inval_en   (btb_inval),
    .upd_pc     (ex_pc),
    .upd_target (ex_target)
  );

  fe_pc_select #(.PC_W(PC_W)) sel_i (
    .ex_fix     (ex_fix),
    .ex_taken   (ex_taken),
    .ex_pc      (ex_pc),
    .ex_target  (ex_target),
    .id_redir   (id_redir),
    .id_target  (id_target),
    .btb_hit    (if_btb_hit),
    .btb_target (btb_target),
    .if_pc      (if_pc),
    .next_pc    (next_pc)
  );
endmodule

// File: rtl/fe_redirect_chk.sv
module fe_redirect_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ex_fix,
  input logic            id_redir,
  input logic            ex_taken,
  input logic [PC_W-1:0] ex_target,
  input logic [PC_W-1:0] if_pc,
  input logic            if_btb_hit,
  input logic [PC_W-1:0] next_pc,
  input logic            if_kill,
  input logic            dec_kill,
  input logic            btb_alloc,
  input logic            btb_inval
);
  a_r2_fix_kills_both: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fix |-> (if_kill && dec_kill));

  a_r2_fix_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fix && ex_taken) |-> (next_pc == ex_target));

  a_r3_decode_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    id_redir |-> (if_kill && !dec_kill));

  a_r9_fix_blocks_decode: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fix |-> !id_redir);

  a_r1_sequential_default: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_kill && !if_btb_hit) |-> (next_pc == if_pc + PC_W'(4)));

  a_r11_alloc_inval_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(btb_alloc && btb_inval));
endmodule

bind fe_redirect_ctrl fe_redirect_chk #(.PC_W(PC_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ex_fix     (ex_fix),
  .id_redir   (id_redir),
  .ex_taken   (ex_taken),
  .ex_target  (ex_target),
  .if_pc      (if_pc),
  .if_btb_hit (if_btb_hit),
  .next_pc    (next_pc),
  .if_kill    (if_kill),
  .dec_kill   (dec_kill),
  .btb_alloc  (btb_alloc),
  .btb_inval  (btb_inval)
);

// File: tb/fe_redirect_ctrl_tb.sv
`timescale 1ns/100ps
module fe_redirect_ctrl_tb_top;
  localparam int PC_W = 32;
  localparam int BHT_IDX_W = 4;
  localparam int BTB_IDX_W = 3;
  localparam int NBHT = 1 << BHT_IDX_W;
  localparam int NBTB = 1 << BTB_IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [PC_W-1:0] if_pc = '0, id_target = '0, ex_pc = '0, ex_target = '0;
  logic [BHT_IDX_W-1:0] id_bht_idx = '0;
  logic id_valid = 0, id_is_branch = 0, id_fetch_taken = 0;
  logic ex_valid = 0, ex_is_branch = 0, ex_taken = 0, ex_pred_taken = 0;
  logic if_btb_hit, id_bht_taken, if_kill, dec_kill, bht_upd, btb_alloc, btb_inval;
  logic [PC_W-1:0] next_pc;

  fe_redirect_ctrl #(.PC_W(PC_W), .BHT_IDX_W(BHT_IDX_W), .BTB_IDX_W(BTB_IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .if_pc(if_pc), .if_btb_hit(if_btb_hit),
    .id_valid(id_valid), .id_is_branch(id_is_branch), .id_bht_idx(id_bht_idx),
    .id_target(id_target), .id_fetch_taken(id_fetch_taken), .id_bht_taken(id_bht_taken),
    .ex_valid(ex_valid), .ex_is_branch(ex_is_branch), .ex_pc(ex_pc), .ex_target(ex_target),
    .ex_taken(ex_taken), .ex_pred_taken(ex_pred_taken), .next_pc(next_pc),
    .if_kill(if_kill), .dec_kill(dec_kill), .bht_upd(bht_upd),
    .btb_alloc(btb_alloc), .btb_inval(btb_inval)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // Independent model of the table state.
  int              m_ctr [NBHT];
  logic            m_bv  [NBTB];
  logic [PC_W-1:0] m_bpc [NBTB];
  logic [PC_W-1:0] m_btgt[NBTB];

  function automatic logic m_pred(input logic [BHT_IDX_W-1:0] idx);
    return m_ctr[idx] >= 2;
  endfunction

  function automatic logic m_hit(input logic [PC_W-1:0] pc);
    int i;
    i = int'(pc[4:2]);
    return m_bv[i] && (m_bpc[i][PC_W-1:5] == pc[PC_W-1:5]);
  endfunction

  function automatic logic m_fix();
    return ex_valid && ex_is_branch && (ex_taken != ex_pred_taken);
  endfunction

  function automatic logic m_redir();
    return id_valid && id_is_branch && m_pred(id_bht_idx) && !id_fetch_taken && !m_fix();
  endfunction

  function automatic logic [PC_W-1:0] m_next();
    if (m_fix()) return ex_taken ? ex_target : ex_pc + 4;
    if (m_redir()) return id_target;
    if (m_hit(if_pc)) return m_btgt[int'(if_pc[4:2])];
    return if_pc + 4;
  endfunction

  task automatic chk(input string req, input string what, input logic [PC_W-1:0] got,
                     input logic [PC_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "next_pc", next_pc, m_next());
    chk(req, "if_kill", 32'(if_kill), 32'(m_fix() || m_redir()));
    chk(req, "dec_kill", 32'(dec_kill), 32'(m_fix()));
    chk(req, "if_btb_hit", 32'(if_btb_hit), 32'(m_hit(if_pc)));
    chk(req, "id_bht_taken", 32'(id_bht_taken), 32'(m_pred(id_bht_idx)));
    chk(req, "bht_upd R11", 32'(bht_upd), 32'(ex_valid && ex_is_branch));
    chk(req, "btb_alloc R11", 32'(btb_alloc), 32'(ex_valid && ex_is_branch && ex_taken));
    chk(req, "btb_inval R11", 32'(btb_inval),
        32'(ex_valid && ex_is_branch && !ex_taken && ex_pred_taken));
  endtask

  // Advance one clock; the model takes the same edge as the design.
  task automatic step();
    @(posedge clk);
    if (ex_valid && ex_is_branch) begin
      int bi, ti;
      bi = int'(ex_pc[2 +: BHT_IDX_W]);
      ti = int'(ex_pc[4:2]);
      if (ex_taken) m_ctr[bi] = (m_ctr[bi] == 3) ? 3 : m_ctr[bi] + 1;
      else          m_ctr[bi] = (m_ctr[bi] == 0) ? 0 : m_ctr[bi] - 1;
      if (ex_taken) begin
        m_bv[ti] = 1'b1; m_bpc[ti] = ex_pc; m_btgt[ti] = ex_target;
      end else if (ex_pred_taken && m_hit(ex_pc)) begin
        m_bv[ti] = 1'b0;
      end
    end
    #0.5;
  endtask

  task automatic idle();
    id_valid = 0; id_is_branch = 0; id_fetch_taken = 0;
    ex_valid = 0; ex_is_branch = 0; ex_taken = 0; ex_pred_taken = 0;
  endtask

  task automatic ex_branch(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                           input logic tk, input logic pr);
    ex_valid = 1; ex_is_branch = 1; ex_pc = pc; ex_target = tgt;
    ex_taken = tk; ex_pred_taken = pr;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBHT; i++) m_ctr[i] = 1;
    for (int i = 0; i < NBTB; i++) begin
      m_bv[i] = 0; m_bpc[i] = '0; m_btgt[i] = '0;
    end
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    step();

    // R12: reset state of both tables, seen through the ports.
    for (int i = 0; i < NBHT; i++) begin
      id_bht_idx = BHT_IDX_W'(i);
      #0.2 chk("R12", "counter reset weak not-taken", 32'(id_bht_taken), 32'd0);
    end
    for (int i = 0; i < NBTB; i++) begin
      if_pc = 32'h0000_4000 + 32'(i * 4);
      #0.2 chk("R12", "btb reset invalid", 32'(if_btb_hit), 32'd0);
    end
    step();

    // R1: plain sequential fetch.
    for (int k = 0; k < 6; k++) begin
      if_pc = 32'h0001_0000 + 32'(k * 52);
      #1 check_all("R1");
      chk("R1", "next_pc seq", next_pc, if_pc + 4);
      step();
    end

    // R4 R5: train every counter through both saturation ends.
    for (int i = 0; i < NBHT; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic o;
        o = (k < 3) || (k == 7);
        ex_branch({20'(k + 1), 6'd0, 4'(i), 2'b00}, 32'h0009_0000 + 32'(i * 64), o, o);
        id_bht_idx = BHT_IDX_W'(i);
        if_pc = 32'h0002_0000;
        #1 check_all("R4 R5");
        step();
      end
      idle();
    end
    // Final counter after T,T,T,N,N,N,N,T from weak not-taken is 1.
    for (int i = 0; i < NBHT; i++) begin
      id_bht_idx = BHT_IDX_W'(i);
      #0.2 chk("R4", "counter after sweep", 32'(id_bht_taken), 32'd0);
    end
    step();

    // R6 R7: target buffer allocate, hit, alias miss, invalidate.
    for (int i = 0; i < NBTB; i++) begin
      logic [PC_W-1:0] pc, tg;
      pc = 32'h0003_0000 + 32'(i * 4);
      tg = 32'h0007_0000 + 32'(i * 16);
      idle();
      ex_branch(pc, tg, 1'b1, 1'b0);
      if_pc = 32'h0005_0000;
      #1 check_all("R2 R6");
      chk("R2", "taken correction target", next_pc, tg);
      step();
      idle();
      if_pc = pc;
      #1 check_all("R6");
      chk("R6", "btb hit", 32'(if_btb_hit), 32'd1);
      chk("R6", "btb target", next_pc, tg);
      if_pc = pc + 32'h20;
      #1 chk("R6", "alias misses", 32'(if_btb_hit), 32'd0);
      chk("R6", "alias seq", next_pc, pc + 32'h24);
      step();
      ex_branch(pc, tg, 1'b0, 1'b1);
      if_pc = 32'h0005_0100;
      #1 check_all("R2 R7");
      chk("R2", "not-taken correction", next_pc, pc + 4);
      chk("R2", "dec_kill on correction", 32'(dec_kill), 32'd1);
      step();
      idle();
      if_pc = pc;
      #1 check_all("R7");
      chk("R7", "btb invalidated", 32'(if_btb_hit), 32'd0);
      step();
    end

    // Prepare: counter 5 strongly taken, target-buffer entry for P.
    begin
      logic [PC_W-1:0] P, PT, Q, QT, X, XT;
      P = 32'h0006_0008; PT = 32'h000A_0000;
      Q = 32'h0006_0014; QT = 32'h000B_0000;
      X = 32'h0006_0100; XT = 32'h000C_0000;
      idle();
      ex_branch(P, PT, 1'b1, 1'b1); step();
      ex_branch(Q, QT, 1'b1, 1'b1); step();
      ex_branch(Q, QT, 1'b1, 1'b1); step();
      idle();

      // R3: decode redirect, single bubble.
      id_valid = 1; id_is_branch = 1; id_bht_idx = Q[5:2]; id_target = QT;
      if_pc = 32'h0006_0200;
      #1 check_all("R3");
      chk("R3", "decode target", next_pc, QT);
      chk("R3", "if_kill", 32'(if_kill), 32'd1);
      chk("R3", "dec_kill low", 32'(dec_kill), 32'd0);

      // R8: decode beats target buffer.
      if_pc = P;
      #1 check_all("R8");
      chk("R8", "decode over btb", next_pc, QT);

      // R10: already steered at fetch, target buffer wins.
      id_fetch_taken = 1;
      #1 check_all("R10");
      chk("R10", "no decode redirect", next_pc, PT);
      chk("R10", "no kill", 32'(if_kill), 32'd0);
      id_fetch_taken = 0;

      // R8 R9: correction from execute beats all.
      ex_branch(X, XT, 1'b1, 1'b0);
      #1 check_all("R8 R9");
      chk("R9", "execute over decode", next_pc, XT);
      chk("R9", "both kills", 32'(if_kill && dec_kill), 32'd1);
      step();
      idle();

      // Non-branch in decode does not redirect (R3).
      id_valid = 1; id_is_branch = 0; id_bht_idx = Q[5:2]; id_target = QT;
      if_pc = 32'h0006_0300;
      #1 check_all("R3");
      chk("R3", "non-branch ignored", next_pc, 32'h0006_0304);
      step();

      // Correct prediction in execute: no kill (R2).
      idle();
      ex_branch(P, PT, 1'b1, 1'b1);
      if_pc = 32'h0006_0400;
      #1 check_all("R2");
      chk("R2", "no kill when predicted right", 32'(dec_kill), 32'd0);
      step();
      idle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule